// File: doc/BRIEF.md
# Dual-Mode 8-Bit Interval/PWM Timer

This block is an 8-bit timer peripheral. Software reaches it through a small register bus with two registers: a control register and a compare register. A single up-counter serves two modes. In interval mode the counter runs from zero up to the compare value, goes back to zero, and toggles a square-wave output each time it matches. In PWM mode the counter runs freely through its full range and wraps. The output is high while the count is below the compare value, so the compare value sets the duty.

The count advances on a tick chosen by two select bits. Three choices come from internal dividers of the system clock. The fourth is a single-cycle tick supplied by an external capture timer. In interval mode a match sets an interrupt flag. The interrupt request output is high when that flag and an enable bit are both set. An output-enable bit routes either a general-purpose port bit or the timer waveform to the pin. The mode bit and the tick-select bits are protected, so they cannot be changed while the timer is running.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, both registers read 00h, `irqOut` is 0, and `pinOut` follows `portValue`.
- R2: Control bit 6 always reads as 0, and writing 1 to it has no effect.
- R3: Control bits 5:4 select the tick source: 0 divides the clock by DIV_A, 1 by DIV_B, 2 by DIV_C, and 3 uses pulses on `extTick`. A write to these bits is ignored while the run bit (control bit 3) is 1.
- R4: Control bit 7 selects the mode: 0 is interval and 1 is PWM. A write to this bit takes effect only if the run bit, the interrupt enable (bit 0) and the flag (bit 2) are all 0 before the write.
- R5: While the run bit is 0, the counter and the square wave are held at 0. After the run bit is set, counting restarts from 00h.
- R6: In interval mode with compare value C and tick period D clock cycles, the square wave first rises (C+1)·D cycles after the write that sets the run bit. After that it toggles every (C+1)·D cycles.
- R7: In interval mode a match sets the flag (control bit 2). Writing 0 to bit 2 clears the flag. Writing 1 to bit 2 leaves it unchanged. If a match and a clearing write happen in the same cycle, the match wins.
- R8: `irqOut` is high exactly when both the flag and the interrupt enable (control bit 0) are 1.
- R9: In PWM mode the output is high for C ticks out of every 256-tick period, starting from the write that sets the run bit. A compare value of 00h gives a constant low output. The flag is never set in this mode.
- R10: Control bit 1 selects the pin source: 0 drives `pinOut` from `portValue`, and 1 drives it from the timer waveform.
- R11: The compare register is at bus address 1 and the control register at address 0. Read data is available combinationally on `busRdData`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | 1 | Register select: 0 = control, 1 = compare |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the register at `busAddr` |
| extTick | input | 1 | External count tick, one cycle per tick |
| portValue | input | 1 | General-purpose port value for the pin |
| pinOut | output | 1 | Pin drive: port value or timer waveform |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with divider settings of 1, 2 and 4 clock cycles. This keeps the cycle counts short enough to sweep every compare value in PWM mode and a broad range of compare values in interval mode, for each internal tick source. With a divider of 1 the counter advances every cycle, so duty and period can be checked as exact cycle counts. The external tick source is driven one pulse at a time, which shows that the counter does not move between pulses.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  localparam int REG_W = 8;

  // Control register bit positions (software-visible layout)
  localparam int B_MODE  = 7;
  localparam int B_SPARE = 6;
  localparam int B_SELHI = 5;
  localparam int B_SELLO = 4;
  localparam int B_RUN   = 3;
  localparam int B_FLAG  = 2;
  localparam int B_OE    = 1;
  localparam int B_IE    = 0;

  typedef enum logic [1:0] {
    SRC_DIV_A = 2'd0,
    SRC_DIV_B = 2'd1,
    SRC_DIV_C = 2'd2,
    SRC_EXT   = 2'd3
  } tickSrc_t;

  // control -> datapath
  typedef struct packed {
    logic     run;
    logic     pwmMode;
    tickSrc_t clkSel;
  } dpCfg_t;

  // datapath -> control
  typedef struct packed {
    logic matchHit;
  } dpEvt_t;

endpackage

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busWrEn,
  input  logic               busAddr,
  input  logic [REG_W-1:0]   busWrData,
  output logic [REG_W-1:0]   busRdData,
  input  dpEvt_t             evt,
  output dpCfg_t             cfg,
  output logic [CNT_W-1:0]   cmpVal,
  output logic               oeSel,
  output logic               irqOut
);

  logic     modeR, runR, flagR, oeR, ieR;
  tickSrc_t clkSelR;
  logic [CNT_W-1:0] cmpR;
  logic wrCtrl, wrCmp;
  logic [REG_W-1:0] ctrlView;

  assign wrCtrl = busWrEn && (busAddr == 1'b0);
  assign wrCmp  = busWrEn && (busAddr == 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeR   <= 1'b0;
      runR    <= 1'b0;
      oeR     <= 1'b0;
      ieR     <= 1'b0;
      clkSelR <= SRC_DIV_A;
    end else if (wrCtrl) begin
      runR <= busWrData[B_RUN];
      oeR  <= busWrData[B_OE];
      ieR  <= busWrData[B_IE];
      if (!runR)
        clkSelR <= tickSrc_t'(busWrData[B_SELHI:B_SELLO]);
      if (!runR && !ieR && !flagR)
        modeR <= busWrData[B_MODE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flagR <= 1'b0;
    else if (evt.matchHit)
      flagR <= 1'b1;
    else if (wrCtrl && !busWrData[B_FLAG])
      flagR <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmpR <= '0;
    else if (wrCmp)
      cmpR <= busWrData[CNT_W-1:0];
  end

  always_comb begin
    ctrlView          = '0;
    ctrlView[B_MODE]  = modeR;
    ctrlView[B_SELHI:B_SELLO] = clkSelR;
    ctrlView[B_RUN]   = runR;
    ctrlView[B_FLAG]  = flagR;
    ctrlView[B_OE]    = oeR;
    ctrlView[B_IE]    = ieR;
  end

  assign busRdData   = busAddr ? REG_W'(cmpR) : ctrlView;
  assign cfg.run     = runR;
  assign cfg.pwmMode = modeR;
  assign cfg.clkSel  = clkSelR;
  assign cmpVal      = cmpR;
  assign oeSel       = oeR;
  assign irqOut      = flagR & ieR;

  AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCtrl && !busAddr && busWrData[B_SPARE]) |=> (busAddr || !busRdData[B_SPARE])); // R2
  AST_CLKSEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(runR) |-> (clkSelR == $past(clkSelR))); // R3
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(runR || ieR || flagR) |-> (modeR == $past(modeR))); // R4
  AST_FLAG_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flagR) && !$past(wrCtrl && !busWrData[B_FLAG])) |-> flagR); // R7
  AST_FLAG_QUIET_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (modeR && !flagR) |=> !flagR); // R9

endmodule

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCfg_t           cfg,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             extTick,
  output dpEvt_t           evt,
  output logic             waveOut
);

  localparam int DIV_MAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                           : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int DIV_W   = $clog2(DIV_MAX) + 1;
  localparam int NUM_INT = 3;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim [NUM_INT];
  logic [DIV_W-1:0] selLim;
  logic intTick, tick, match, squareR;
  logic [CNT_W-1:0] cnt;

  genvar g;
  generate
    for (g = 0; g < NUM_INT; g++) begin : gLim
      localparam int DV = (g == 0) ? DIV_A : ((g == 1) ? DIV_B : DIV_C);
      assign divLim[g] = DIV_W'(DV - 1);
    end
  endgenerate

  always_comb begin
    case (cfg.clkSel)
      SRC_DIV_A: selLim = divLim[0];
      SRC_DIV_B: selLim = divLim[1];
      default:   selLim = divLim[2];
    endcase
  end

  assign intTick = (divCnt == selLim);
  assign tick    = cfg.run && ((cfg.clkSel == SRC_EXT) ? extTick : intTick);
  assign match   = tick && !cfg.pwmMode && (cnt == cmpVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      divCnt <= '0;
    else if (!cfg.run || intTick)
      divCnt <= '0;
    else
      divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!cfg.run)
      cnt <= '0;
    else if (tick)
      cnt <= match ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      squareR <= 1'b0;
    else if (!cfg.run)
      squareR <= 1'b0;
    else if (match)
      squareR <= ~squareR;
  end

  assign evt.matchHit = match;
  assign waveOut      = cfg.pwmMode ? (cnt < cmpVal) : squareR;

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |=> (cnt == '0 && !squareR)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg.run) && !$past(tick)) |-> (cnt == $past(cnt))); // R3
  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    evt.matchHit |=> (squareR != $past(squareR))); // R6
  AST_PWM_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pwmMode && cmpVal == '0) |-> !waveOut); // R9

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busWrEn,
  input  logic             busAddr,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] busRdData,
  input  logic             extTick,
  input  logic             portValue,
  output logic             pinOut,
  output logic             irqOut
);

  dpCfg_t cfg;
  dpEvt_t evt;
  logic [CNT_W-1:0] cmpVal;
  logic oeSel, waveOut;

  dmt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .evt(evt), .cfg(cfg), .cmpVal(cmpVal),
    .oeSel(oeSel), .irqOut(irqOut)
  );

  dmt_datapath #(.CNT_W(CNT_W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .cfg(cfg), .cmpVal(cmpVal), .extTick(extTick),
    .evt(evt), .waveOut(waveOut)
  );

  assign pinOut = oeSel ? waveOut : portValue;

  AST_PIN_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !oeSel |-> (pinOut == portValue)); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.pwmMode && $past(cfg.pwmMode) && !$past(irqOut)) |-> !irqOut || $past(busWrEn)); // R8

endmodule

// File: tb/dual_mode_timer_tb.sv
`timescale 1ns/1ps
module dual_mode_timer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWrEn = 1'b0;
  logic busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic extTick = 1'b0;
  logic portValue = 1'b1;
  logic pinOut, irqOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dual_mode_timer #(.CNT_W(8), .DIV_A(1), .DIV_B(2), .DIV_C(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .extTick(extTick), .portValue(portValue),
    .pinOut(pinOut), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    busAddr = a; #1;
    d = busRdData;
  endtask

  task automatic stopAll();
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h00);
  endtask

  task automatic waitPin(input logic lvl, input int limit, output int n);
    n = 0;
    while (pinOut !== lvl && n < limit) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic runInterval(input int c, input int sel, input int d);
    logic [7:0] r;
    int n;
    wr(1'b1, 8'(c));
    wr(1'b0, 8'(8'h0A | (sel << 4)));
    waitPin(1'b1, 4000, n);
    chk("R6", n, (c + 1) * d, $sformatf("first rise c=%0d sel=%0d", c, sel));
    waitPin(1'b0, 4000, n);
    chk("R6", n, (c + 1) * d, $sformatf("half period c=%0d sel=%0d", c, sel));
    rd(1'b0, r);
    chk("R7", int'(r[2]), 1, "flag set by match");
    chk("R3", int'(r[5:4]), sel, "tick select readback");
    stopAll();
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n, hi;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;

    // R1 reset state
    rd(1'b0, r); chk("R1", int'(r), 0, "ctrl after reset");
    rd(1'b1, r); chk("R1", int'(r), 0, "cmp after reset");
    chk("R1", int'(irqOut), 0, "irq after reset");
    chk("R1", int'(pinOut), 1, "pin follows port after reset");

    // R11 compare register address
    wr(1'b1, 8'h5A); rd(1'b1, r); chk("R11", int'(r), 8'h5A, "cmp readback");

    // R2 spare bit
    wr(1'b0, 8'h40); rd(1'b0, r); chk("R2", int'(r), 0, "spare bit reads 0");

    // R3 tick select lock
    wr(1'b0, 8'h08); wr(1'b0, 8'h38); rd(1'b0, r);
    chk("R3", int'(r), 8'h38 & 8'hCF, "select write ignored while running");
    stopAll();
    wr(1'b0, 8'h30); rd(1'b0, r); chk("R3", int'(r), 8'h30, "select write while stopped");
    stopAll();

    // R4 mode lock
    wr(1'b0, 8'h01); wr(1'b0, 8'h81); rd(1'b0, r);
    chk("R4", int'(r), 8'h01, "mode rejected with ie set");
    stopAll();
    wr(1'b0, 8'h08); wr(1'b0, 8'h88); rd(1'b0, r);
    chk("R4", int'(r), 8'h08, "mode rejected while running");
    stopAll();

    // R6/R3 interval sweeps
    for (int c = 0; c <= 20; c++) runInterval(c, 0, 1);
    runInterval(255, 0, 1);
    for (int c = 0; c <= 5; c++) runInterval(c, 1, 2);
    for (int c = 0; c <= 5; c++) runInterval(c, 2, 4);

    // R4 mode rejected while flag set
    wr(1'b1, 8'd0); wr(1'b0, 8'h08); wr(1'b0, 8'h04);
    rd(1'b0, r); chk("R7", int'(r), 8'h04, "flag kept by stop write with bit2=1");
    wr(1'b0, 8'h84); rd(1'b0, r); chk("R4", int'(r), 8'h04, "mode rejected with flag set");
    stopAll();

    // R5 stop mid-count then restart from zero
    wr(1'b1, 8'd10); wr(1'b0, 8'h0A);
    repeat (5) @(posedge clk); #1;
    wr(1'b0, 8'h02);
    repeat (20) @(posedge clk); #1;
    chk("R5", int'(pinOut), 0, "square held low while stopped");
    wr(1'b0, 8'h0A);
    waitPin(1'b1, 4000, n);
    chk("R5", n, 11, "restart counts from zero");
    stopAll();

    // R7/R8 flag and interrupt
    wr(1'b1, 8'd255); wr(1'b0, 8'h09);
    repeat (256) @(posedge clk); #1;
    chk("R8", int'(irqOut), 1, "irq with flag and enable");
    wr(1'b0, 8'h0C);
    rd(1'b0, r); chk("R7", int'(r[2]), 1, "write 1 keeps flag");
    chk("R8", int'(irqOut), 0, "irq gated by enable");
    wr(1'b0, 8'h0D); chk("R8", int'(irqOut), 1, "irq back on");
    wr(1'b0, 8'h09);
    rd(1'b0, r); chk("R7", int'(r[2]), 0, "write 0 clears flag");
    chk("R8", int'(irqOut), 0, "irq low after clear");
    stopAll();

    // R9 PWM sweep over every compare value
    for (int c = 0; c < 256; c++) begin
      wr(1'b1, 8'(c));
      wr(1'b0, 8'h8B);
      hi = 0;
      for (int k = 0; k < 256; k++) begin
        if (k > 0) begin @(posedge clk); #1; end
        hi += int'(pinOut);
      end
      chk("R9", hi, c, $sformatf("pwm high cycles c=%0d", c));
      rd(1'b0, r);
      chk("R9", int'(r[2]) + int'(irqOut), 0, "no flag or irq in pwm");
      wr(1'b0, 8'h80);
    end
    rd(1'b0, r); chk("R4", int'(r[7]), 1, "pwm mode accepted when idle");

    // R9 with slower tick
    wr(1'b1, 8'd100); wr(1'b0, 8'h9A);
    hi = 0;
    for (int k = 0; k < 512; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      hi += int'(pinOut);
    end
    chk("R9", hi, 200, "pwm high cycles with divide-by-2");

    // R10 pin source select
    wr(1'b1, 8'd255); wr(1'b0, 8'h88);
    portValue = 1'b0; #1;
    chk("R10", int'(pinOut), 0, "port value 0 on pin");
    portValue = 1'b1; #1;
    chk("R10", int'(pinOut), 1, "port value 1 on pin");
    portValue = 1'b0;
    wr(1'b0, 8'h8A);
    chk("R10", int'(pinOut), 1, "waveform on pin");
    wr(1'b0, 8'h80);
    stopAll();
    rd(1'b0, r); chk("R4", int'(r[7]), 0, "back to interval mode");

    // R3 external tick source
    wr(1'b1, 8'd2); wr(1'b0, 8'h3A);
    for (int p = 1; p <= 6; p++) begin
      repeat (7) @(posedge clk); #1;
      @(negedge clk); extTick = 1'b1;
      @(posedge clk); #1; extTick = 1'b0;
      chk("R3", int'(pinOut), (p >= 3 && p < 6) ? 1 : 0, $sformatf("ext tick pulse %0d", p));
    end
    stopAll();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule